// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns one modified virtual address into a physical base address and its attributes by reading translation descriptors from memory. A cache controller or address-translation unit starts it only when its own cached translation is missing, handing over the translation table base and the address to resolve. The walker then reads one or two 32-bit descriptors through a request/grant/response read port, with at most one read in flight.

The first-level descriptor either maps a 1 MB section straight away, reports a fault, or points to one of two second-level table formats. The coarse format holds 256 entries and maps 64 KB and 4 KB pages. The fine format holds 1024 entries and also maps 1 KB pages. When the walk ends, the walker gives a one-cycle completion pulse. It then holds the physical base, the page size class, the 4-bit domain, eight permission bits (one 2-bit field per quarter page) and a fault flag until the next walk starts. Memory-side tables repeat large-page entries, so the walker indexes every second-level table the same way whatever page size it finds.

Top module: `ttw_walker`

## Requirements
- R1: While reset is high and in the cycle after it falls, `rd_req`, `busy`, `done` and `fault` are 0 and `phys_base` is 0.
- R2: The first read goes to address {ttb[31:14], mva[31:20], 2'b00}. `mva` and `ttb` are sampled in the cycle `start` is taken.
- R3: First-level descriptor bits [1:0] = 00 ends the walk after one read with `fault`=1, `phys_base`=0, `perm`=0 and `page_size`=0.
- R4: First-level bits [1:0] = 10 (section) ends the walk after one read with `phys_base`={d[31:20], 20'b0}, `page_size`=0 and `perm` set to d[11:10] repeated four times.
- R5: First-level bits [1:0] = 01 (coarse) makes the second read go to {d[31:10], mva[19:12], 2'b00}. Bits [1:0] = 11 (fine) makes it go to {d[31:12], mva[19:10], 2'b00}.
- R6: Second-level bits [1:0] = 01 (large page) gives `phys_base`={d[31:16], 16'b0}, `page_size`=1 and `perm`=d[11:4].
- R7: Second-level bits [1:0] = 10 (small page) gives `phys_base`={d[31:12], 12'b0}, `page_size`=2 and `perm`=d[11:4].
- R8: Second-level bits [1:0] = 11 (tiny page) from a fine table gives `phys_base`={d[31:10], 10'b0}, `page_size`=3 and `perm` set to d[5:4] repeated four times. From a coarse table it is a fault.
- R9: Second-level bits [1:0] = 00 gives `fault`=1, `phys_base`=0, `perm`=0 and `page_size`=0. In every outcome, `domain` equals bits [8:5] of the first-level descriptor.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_gnt`. No new request is made before the response to the previous one. A `start` pulse during a walk is ignored and launches no further read.
- R11: `done` is high for exactly one cycle, in the cycle after the response that ends the walk. `busy` is low in the cycle after `done`. The results stay unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; taken only when idle |
| ttb | input | 32 | Translation table base address |
| mva | input | 32 | Modified virtual address to resolve |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_gnt | input | 1 | Read request accepted this cycle |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data (descriptor) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Translation fault result |
| phys_base | output | 32 | Physical base of the mapped region |
| page_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| domain | output | 4 | Domain from the first-level descriptor |
| perm | output | 8 | Permission field per quarter page, quarter 0 in bits [1:0] |

## Verification
The hardest case to reach from the ports is a tiny-page descriptor returned from a coarse table, together with a start pulse that arrives while a read is still outstanding. Grant delay and response latency also vary, so the read sequencing is exercised across different timings. The bench sweeps all sixteen pairs of first-level and second-level descriptor types over several address patterns, with grant delays of 0 to 2 cycles and response latencies of 0 to 3 cycles. For one pattern it injects a stray start, carrying a different address, in the middle of the walk. Every expected address and result is computed arithmetically from the descriptor fields.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int ADDR_W   = 32;
  localparam int DOM_W    = 4;
  localparam int DOM_LSB  = 5;
  localparam int AP_W     = 2;
  localparam int SUBPAGES = 4;
  localparam int PERM_W   = AP_W * SUBPAGES;
  localparam int SEC_AP_LSB  = 10;
  localparam int PAGE_AP_LSB = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0, PG_LARGE = 2'd1, PG_SMALL = 2'd2, PG_TINY = 2'd3
  } page_size_e;

  typedef enum logic [1:0] {
    L1_FAULT = 2'd0, L1_COARSE = 2'd1, L1_SECTION = 2'd2, L1_FINE = 2'd3
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'd0, L2_LARGE = 2'd1, L2_SMALL = 2'd2, L2_TINY = 2'd3
  } l2_kind_e;

  typedef struct packed {
    logic                fault;
    page_size_e          size;
    logic [ADDR_W-1:0]   base;
    logic [PERM_W-1:0]   perm;
  } xlat_t;

  localparam xlat_t XLAT_FAULT = '{fault: 1'b1, size: PG_SECTION,
                                   base: '0, perm: '0};
endpackage

// File: rtl/ttw_l1_dec.sv
module ttw_l1_dec
  import ttw_pkg::*;
#(
  parameter int L1_IDX_W     = 12,
  parameter int COARSE_IDX_W = 8,
  parameter int FINE_IDX_W   = 10
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] mva,
  output l1_kind_e          kind,
  output logic              descend,
  output logic              is_fine,
  output logic [DOM_W-1:0]  dom,
  output logic [ADDR_W-1:0] l2_addr,
  output xlat_t             sec_res
);
  localparam int SEC_SHIFT   = ADDR_W - L1_IDX_W;
  localparam int C_IDX_LSB   = SEC_SHIFT - COARSE_IDX_W;
  localparam int C_BASE_LSB  = COARSE_IDX_W + 2;
  localparam int F_IDX_LSB   = SEC_SHIFT - FINE_IDX_W;
  localparam int F_BASE_LSB  = FINE_IDX_W + 2;

  logic [ADDR_W-1:0] coarse_addr;
  logic [ADDR_W-1:0] fine_addr;

  assign kind    = l1_kind_e'(desc[1:0]);
  assign descend = (kind == L1_COARSE) || (kind == L1_FINE);
  assign is_fine = (kind == L1_FINE);
  assign dom     = desc[DOM_LSB +: DOM_W];

  assign coarse_addr = {desc[ADDR_W-1:C_BASE_LSB], mva[SEC_SHIFT-1:C_IDX_LSB], 2'b00};
  assign fine_addr   = {desc[ADDR_W-1:F_BASE_LSB], mva[SEC_SHIFT-1:F_IDX_LSB], 2'b00};
  assign l2_addr     = is_fine ? fine_addr : coarse_addr;

  always_comb begin
    if (kind == L1_SECTION) begin
      sec_res.fault = 1'b0;
      sec_res.size  = PG_SECTION;
      sec_res.base  = {desc[ADDR_W-1:SEC_SHIFT], {SEC_SHIFT{1'b0}}};
      sec_res.perm  = {SUBPAGES{desc[SEC_AP_LSB +: AP_W]}};
    end else begin
      sec_res = XLAT_FAULT;
    end
  end
endmodule

// File: rtl/ttw_l2_dec.sv
module ttw_l2_dec
  import ttw_pkg::*;
#(
  parameter int LARGE_SHIFT = 16,
  parameter int SMALL_SHIFT = 12,
  parameter int TINY_SHIFT  = 10
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic              from_fine,
  output xlat_t             res
);
  l2_kind_e kind;
  assign kind = l2_kind_e'(desc[1:0]);

  always_comb begin
    res = XLAT_FAULT;
    unique case (kind)
      L2_LARGE: begin
        res.fault = 1'b0;
        res.size  = PG_LARGE;
        res.base  = {desc[ADDR_W-1:LARGE_SHIFT], {LARGE_SHIFT{1'b0}}};
        res.perm  = desc[PAGE_AP_LSB +: PERM_W];
      end
      L2_SMALL: begin
        res.fault = 1'b0;
        res.size  = PG_SMALL;
        res.base  = {desc[ADDR_W-1:SMALL_SHIFT], {SMALL_SHIFT{1'b0}}};
        res.perm  = desc[PAGE_AP_LSB +: PERM_W];
      end
      L2_TINY: begin
        if (from_fine) begin
          res.fault = 1'b0;
          res.size  = PG_TINY;
          res.base  = {desc[ADDR_W-1:TINY_SHIFT], {TINY_SHIFT{1'b0}}};
          res.perm  = {SUBPAGES{desc[PAGE_AP_LSB +: AP_W]}};
        end
      end
      default: res = XLAT_FAULT;
    endcase
  end
endmodule

// File: rtl/ttw_ctrl.sv
module ttw_ctrl
  import ttw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] l1_addr,
  input  logic [ADDR_W-1:0] l2_addr,
  input  logic              l1_descend,
  input  logic              rd_gnt,
  input  logic              rd_rvalid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accept,
  output logic              l1_take,
  output logic              l2_take,
  output logic              busy,
  output logic              done
);
  walk_state_e st, st_n;

  assign accept  = (st == S_IDLE) && start;
  assign l1_take = (st == S_L1_WAIT) && rd_rvalid;
  assign l2_take = (st == S_L2_WAIT) && rd_rvalid;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:    if (start)     st_n = S_L1_REQ;
      S_L1_REQ:  if (rd_gnt)    st_n = S_L1_WAIT;
      S_L1_WAIT: if (rd_rvalid) st_n = l1_descend ? S_L2_REQ : S_DONE;
      S_L2_REQ:  if (rd_gnt)    st_n = S_L2_WAIT;
      S_L2_WAIT: if (rd_rvalid) st_n = S_DONE;
      S_DONE:                   st_n = S_IDLE;
      default:                  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      rd_addr <= '0;
      rd_req  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      st     <= st_n;
      rd_req <= (st_n == S_L1_REQ) || (st_n == S_L2_REQ);
      busy   <= (st_n != S_IDLE);
      done   <= (st_n == S_DONE);
      if (accept)
        rd_addr <= l1_addr;
      else if (l1_take && l1_descend)
        rd_addr <= l2_addr;
    end
  end

  // R10: request held with a stable address until granted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));
  // R10: a granted request drops at once; no back-to-back reads
  p_one_out_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_gnt |=> !rd_req);
  // R11: completion is a single-cycle pulse followed by idle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  // R2: descriptor reads are word aligned
  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[1:0] == 2'b00);
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
  import ttw_pkg::*;
#(
  parameter int L1_IDX_W     = 12,
  parameter int COARSE_IDX_W = 8,
  parameter int FINE_IDX_W   = 10,
  parameter int LARGE_SHIFT  = 16,
  parameter int SMALL_SHIFT  = 12,
  parameter int TINY_SHIFT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       ttb,
  input  logic [31:0]       mva,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_rvalid,
  input  logic [31:0]       rd_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [31:0]       phys_base,
  output logic [1:0]        page_size,
  output logic [3:0]        domain,
  output logic [7:0]        perm
);
  localparam int SEC_SHIFT = ADDR_W - L1_IDX_W;
  localparam int TBL_LSB   = L1_IDX_W + 2;

  logic [ADDR_W-1:0] mva_q;
  logic              fine_q;
  logic [ADDR_W-1:0] l1_addr;
  logic              accept, l1_take, l2_take;

  l1_kind_e          l1_kind;
  logic              l1_descend, l1_fine;
  logic [DOM_W-1:0]  l1_dom;
  logic [ADDR_W-1:0] l2_addr;
  xlat_t             l1_res, l2_res, res_q;

  assign l1_addr = {ttb[ADDR_W-1:TBL_LSB], mva[ADDR_W-1:SEC_SHIFT], 2'b00};

  ttw_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .l1_addr    (l1_addr),
    .l2_addr    (l2_addr),
    .l1_descend (l1_descend),
    .rd_gnt     (rd_gnt),
    .rd_rvalid  (rd_rvalid),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .accept     (accept),
    .l1_take    (l1_take),
    .l2_take    (l2_take),
    .busy       (busy),
    .done       (done)
  );

  ttw_l1_dec #(
    .L1_IDX_W     (L1_IDX_W),
    .COARSE_IDX_W (COARSE_IDX_W),
    .FINE_IDX_W   (FINE_IDX_W)
  ) u_l1 (
    .desc    (rd_rdata),
    .mva     (mva_q),
    .kind    (l1_kind),
    .descend (l1_descend),
    .is_fine (l1_fine),
    .dom     (l1_dom),
    .l2_addr (l2_addr),
    .sec_res (l1_res)
  );

  ttw_l2_dec #(
    .LARGE_SHIFT (LARGE_SHIFT),
    .SMALL_SHIFT (SMALL_SHIFT),
    .TINY_SHIFT  (TINY_SHIFT)
  ) u_l2 (
    .desc      (rd_rdata),
    .from_fine (fine_q),
    .res       (l2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mva_q  <= '0;
      fine_q <= 1'b0;
      domain <= '0;
      res_q  <= '{fault: 1'b0, size: PG_SECTION, base: '0, perm: '0};
    end else begin
      if (accept)
        mva_q <= mva;
      if (l1_take) begin
        domain <= l1_dom;
        fine_q <= l1_fine;
        if (!l1_descend)
          res_q <= l1_res;
      end
      if (l2_take)
        res_q <= l2_res;
    end
  end

  assign fault     = res_q.fault;
  assign phys_base = res_q.base;
  assign page_size = res_q.size;
  assign perm      = res_q.perm;

  // R9: a fault never leaves a base address or permissions behind
  p_fault_clean_r9: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> phys_base == '0 && perm == '0);
  // R4: sections are 1 MB aligned
  p_section_align_r4: assert property (@(posedge clk) disable iff (rst)
    done && !fault && page_size == PG_SECTION |-> phys_base[SEC_SHIFT-1:0] == '0);
  // R8: tiny pages come only from fine tables
  p_tiny_fine_r8: assert property (@(posedge clk) disable iff (rst)
    done && !fault && page_size == PG_TINY |-> fine_q);
  // R11: results stay put between walks
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) && !start |=> $stable(phys_base) && $stable(perm) && $stable(domain));
endmodule

// File: tb/ttw_walker_tb.sv
module ttw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ttb = '0;
  logic [31:0] mva = '0;
  logic        rd_req, rd_gnt, busy, done, fault;
  logic        rd_rvalid = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic [31:0] rd_addr, phys_base;
  logic [1:0]  page_size;
  logic [3:0]  domain;
  logic [7:0]  perm;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ttw_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .ttb(ttb), .mva(mva),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .busy(busy), .done(done),
    .fault(fault), .phys_base(phys_base), .page_size(page_size),
    .domain(domain), .perm(perm)
  );

  // memory model: first read returns d1, second d2
  logic [31:0] d1, d2;
  logic [1:0]  gdelay_cfg = 2'd0, lat_cfg = 2'd0;
  logic        clr = 1'b0;
  logic [1:0]  gw;
  logic        pend;
  logic [1:0]  lat;
  logic [31:0] pdata;
  int          reads, overlap;
  logic [31:0] alog0, alog1;

  assign rd_gnt = rd_req && (gw == 2'd0);

  always @(posedge clk) begin
    rd_rvalid <= 1'b0;
    if (rst || clr) begin
      gw <= gdelay_cfg; pend <= 1'b0; lat <= '0; reads <= 0; overlap <= 0;
      alog0 <= '0; alog1 <= '0;
    end else begin
      if (!rd_req) gw <= gdelay_cfg;
      else if (!rd_gnt) gw <= gw - 2'd1;
      if (rd_gnt) begin
        if (pend) overlap <= overlap + 1;
        pend  <= 1'b1;
        lat   <= lat_cfg;
        pdata <= (reads == 0) ? d1 : d2;
        if (reads == 0) alog0 <= rd_addr;
        if (reads == 1) alog1 <= rd_addr;
        reads <= reads + 1;
        gw    <= gdelay_cfg;
      end else if (pend) begin
        if (lat == 2'd0) begin
          rd_rvalid <= 1'b1; rd_rdata <= pdata; pend <= 1'b0;
        end else lat <= lat - 2'd1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int a);
    logic [31:0] h;
    h = 32'(a) * 32'h9E37_79B1;
    return h ^ (h >> 13) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic walk(input logic [31:0] t, input logic [31:0] v,
                      input logic [31:0] a, input logic [31:0] b,
                      input int gd, input int lt, input bit inject);
    logic [31:0] e_l1a, e_l2a, e_base;
    logic [7:0]  e_perm;
    logic [1:0]  e_size;
    logic        e_fault;
    int          e_reads, k, rv_k, done_k;
    string       tag;
    logic [31:0] held;

    e_l1a = {t[31:14], v[31:20], 2'b00};
    e_l2a = '0; e_fault = 1'b1; e_base = '0; e_perm = '0; e_size = 2'd0;
    e_reads = 1; tag = "R3";
    case (a[1:0])
      2'b00: tag = "R3";
      2'b10: begin
        tag = "R4"; e_fault = 1'b0; e_base = {a[31:20], 20'h0};
        e_perm = {4{a[11:10]}};
      end
      default: begin
        e_reads = 2;
        e_l2a = (a[1:0] == 2'b11) ? {a[31:12], v[19:10], 2'b00}
                                  : {a[31:10], v[19:12], 2'b00};
        case (b[1:0])
          2'b00: tag = "R9";
          2'b01: begin tag = "R6"; e_fault = 1'b0; e_size = 2'd1;
                       e_base = {b[31:16], 16'h0}; e_perm = b[11:4]; end
          2'b10: begin tag = "R7"; e_fault = 1'b0; e_size = 2'd2;
                       e_base = {b[31:12], 12'h0}; e_perm = b[11:4]; end
          default: begin
            tag = "R8";
            if (a[1:0] == 2'b11) begin
              e_fault = 1'b0; e_size = 2'd3;
              e_base = {b[31:10], 10'h0}; e_perm = {4{b[5:4]}};
            end
          end
        endcase
      end
    endcase

    @(negedge clk);
    d1 = a; d2 = b; gdelay_cfg = 2'(gd); lat_cfg = 2'(lt); clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; ttb = t; mva = v; start = 1'b1;
    k = 0; rv_k = -10; done_k = -1;
    while (done_k < 0 && k < 200) begin
      @(negedge clk);
      k++;
      if (k == 1) begin start = 1'b0; mva = ~v; ttb = ~t; end
      if (inject && k == 2) start = 1'b1;
      if (inject && k == 3) start = 1'b0;
      if (rd_rvalid) rv_k = k;
      if (done) done_k = k;
    end
    start = 1'b0;
    chk(done_k >= 0, "R11", "walk completes", 32'(done_k), 32'(k));
    chk(done_k == rv_k + 1, "R11", "done one cycle after response",
        32'(done_k), 32'(rv_k + 1));
    chk(fault == e_fault, tag, "fault", {31'b0, fault}, {31'b0, e_fault});
    chk(phys_base == e_base, tag, "phys_base", phys_base, e_base);
    chk(page_size == e_size, tag, "page_size", {30'b0, page_size}, {30'b0, e_size});
    chk(perm == e_perm, tag, "perm", {24'b0, perm}, {24'b0, e_perm});
    chk(domain == a[8:5], "R9", "domain from first level", {28'b0, domain}, {28'b0, a[8:5]});
    chk(alog0 == e_l1a, "R2", "first-level address", alog0, e_l1a);
    if (e_reads == 2)
      chk(alog1 == e_l2a, "R5", "second-level address", alog1, e_l2a);
    held = phys_base;
    @(negedge clk);
    chk(!done && !busy, "R11", "single done pulse then idle",
        {30'b0, done, busy}, 32'd0);
    repeat (3) @(negedge clk);
    chk(reads == e_reads, "R10", "read count", 32'(reads), 32'(e_reads));
    chk(overlap == 0 && !rd_req, "R10", "no overlapping or stray reads",
        32'(overlap), 32'd0);
    chk(phys_base == held, "R11", "results held", phys_base, held);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!rd_req && !busy && !done && !fault, "R1", "reset outputs",
        {28'b0, rd_req, busy, done, fault}, 32'd0);
    chk(phys_base == 32'd0, "R1", "reset phys_base", phys_base, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req && !busy && !done, "R1", "after reset",
        {29'b0, rd_req, busy, done}, 32'd0);
    for (int k1 = 0; k1 < 4; k1++)
      for (int k2 = 0; k2 < 4; k2++)
        for (int p = 0; p < 6; p++) begin
          logic [31:0] a, b;
          int seed;
          seed = k1 * 97 + k2 * 31 + p * 7 + 1;
          a = {mix(seed + 3)[31:2], 2'(k1)};
          b = {mix(seed + 5)[31:2], 2'(k2)};
          walk(mix(seed), mix(seed + 11), a, b, p % 3, (p + k2) % 4, p == 4);
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule